// File: doc/BRIEF.md
# Nibble-RAM Bank Controller

This block sits between a CPU bus and a cartridge ROM. It also holds a small on-chip RAM that is 512 entries deep and 4 bits wide. A CPU write to the lowest 16 KB of the address space goes to one of two control registers, picked by address bit 8. One is a 4-bit ROM bank number. The other is a RAM enable flag.

For reads, the block turns the CPU address into a linear byte address for an external ROM. The fixed 16 KB window is passed through unchanged. The switchable 16 KB window is offset by the selected bank and wrapped to the ROM size. In the 8 KB RAM window, the block returns a stored nibble with its upper four bits forced high. Only the low nine address bits index the RAM, so its contents repeat across the whole window.

Both read paths are combinational. All writes are registered. The ROM size is a parameter and must be a power of two multiple of 16 KB, from 16 KB up to 256 KB, so that the wrap is a plain address mask.

Top module: `nibram_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1 and the RAM is disabled. A read at 0x4000 gives rom_addr 0x4000, and ram_rdata reads 0xFF.
- R2: A write at an address in 0x0000–0x3FFF with address bit 8 = 1 loads the bank from wdata[3:0]. wdata[7:4] is ignored.
- R3: A bank write whose low nibble is 0 selects bank 1.
- R4: A write at an address in 0x0000–0x3FFF with address bit 8 = 0 enables the RAM when wdata[3:0] = 0xA. Any other low nibble disables it, and wdata[7:4] is ignored. This write leaves the bank unchanged.
- R5: For an address in 0x0000–0x3FFF, rom_addr equals the address.
- R6: For an address in 0x4000–0x7FFF, rom_addr = (bank × 0x4000 + (address − 0x4000)) mod ROM_BYTES.
- R7: The RAM entry used is address[8:0]. Every address in 0xA000–0xBFFF with the same low nine bits reaches the same entry.
- R8: While the RAM is enabled, ram_rdata = {4'hF, stored nibble}. While it is disabled, ram_rdata = 0xFF.
- R9: A write at an address in 0xA000–0xBFFF stores only wdata[3:0], and only while the RAM is enabled. While the RAM is disabled the write leaves the entry unchanged.
- R10: A write at an address in 0x4000–0x7FFF changes neither the bank nor the RAM enable.
- R11: A register or RAM write takes effect at the rising clock edge on which wr is high. Reads reflect it right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| rom_addr | output | ROM_AW | Linear ROM byte address for reads below 0x8000 |
| ram_rdata | output | 8 | RAM read byte for the 0xA000–0xBFFF window |

## Verification
The two read results, rom_addr and ram_rdata, are combinational. Each is due within the same cycle as its address. The bench therefore settles the address between edges and samples one time step later. Every write changes a register or a RAM entry at the single rising edge where cpu_wr is high. The bench drives each write at the falling edge, lets exactly one rising edge pass, and reads the effect back through the read ports. That same read also proves that ignored writes (R9, R10) left the state alone.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  localparam int CPU_AW    = 16;
  localparam int NIB_W     = 4;
  localparam int BANK_SH   = 14;          // log2 of the 16 KB window size
  localparam int MAP_W     = NIB_W + BANK_SH;
  localparam logic [NIB_W-1:0] EN_KEY = 4'hA;

  // lowest 16 KB: control-register writes and fixed ROM reads
  function automatic logic in_fixed(input logic [CPU_AW-1:0] a);
    return a[15:14] == 2'b00;
  endfunction

  // second 16 KB: switchable ROM window
  function automatic logic in_banked(input logic [CPU_AW-1:0] a);
    return a[15:14] == 2'b01;
  endfunction

  // 8 KB RAM window at 0xA000
  function automatic logic in_ram(input logic [CPU_AW-1:0] a);
    return a[15:13] == 3'b101;
  endfunction

  function automatic logic [NIB_W-1:0] bank_fix(input logic [NIB_W-1:0] n);
    return (n == '0) ? NIB_W'(1) : n;
  endfunction

  function automatic logic en_decode(input logic [NIB_W-1:0] n);
    return n == EN_KEY;
  endfunction

endpackage

// File: rtl/nbc_ctrl_regs.sv
module nbc_ctrl_regs
  import nbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_wr_ev,
  input  logic             en_wr_ev,
  input  logic [NIB_W-1:0] wr_nib,
  output logic [NIB_W-1:0] bank,
  output logic             ram_en
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank   <= NIB_W'(1);
      ram_en <= 1'b0;
    end else begin
      if (bank_wr_ev) bank   <= bank_fix(wr_nib);
      if (en_wr_ev)   ram_en <= en_decode(wr_nib);
    end
  end

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_ev && (wr_nib != '0) |=> bank == $past(wr_nib));

  // R3
  bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_ev && (wr_nib == '0) |=> bank == NIB_W'(1));

  // R4
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_ev |=> (ram_en == ($past(wr_nib) == 4'hA)) && $stable(bank));

endmodule

// File: rtl/nbc_rom_map.sv
module nbc_rom_map
  import nbc_pkg::*;
#(
  parameter int ROM_BYTES = 131072,
  localparam int ROM_AW   = $clog2(ROM_BYTES)
)(
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [NIB_W-1:0]  bank,
  output logic [ROM_AW-1:0] rom_addr
);

  // The bank number sits above the 14-bit window offset. Keeping only the
  // low ROM_AW bits is the same as taking the result modulo ROM_BYTES.
  function automatic logic [ROM_AW-1:0] map_addr(input logic [CPU_AW-1:0] a,
                                                 input logic [NIB_W-1:0]  b);
    logic [MAP_W-1:0] full;
    if (in_banked(a)) full = {b, a[BANK_SH-1:0]};
    else              full = {{NIB_W{1'b0}}, a[BANK_SH-1:0]};
    return full[ROM_AW-1:0];
  endfunction

  assign rom_addr = map_addr(cpu_addr, bank);

endmodule

// File: rtl/nbc_nibble_ram.sv
module nbc_nibble_ram
  import nbc_pkg::*;
#(
  parameter int DEPTH  = 512,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [NIB_W-1:0] wnib,
  output logic [NIB_W-1:0] rnib
);

  logic [NIB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wnib;
  end

  assign rnib = mem[idx];

  // R9
  ram_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we && $stable(idx) |=> rnib == $past(wnib));

endmodule

// File: rtl/nibram_bank_ctrl.sv
module nibram_bank_ctrl
  import nbc_pkg::*;
#(
  parameter int ROM_BYTES = 131072,
  parameter int RAM_DEPTH = 512,
  localparam int ROM_AW   = $clog2(ROM_BYTES),
  localparam int IDX_W    = $clog2(RAM_DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [7:0]        ram_rdata
);

  // named events, also used by the assertions
  logic             reg_wr_ev, bank_wr_ev, en_wr_ev, ram_wr_ev, dead_wr_ev;
  logic [NIB_W-1:0] bank, stored_nib, wr_nib;
  logic             ram_en;

  assign wr_nib     = cpu_wdata[NIB_W-1:0];
  assign reg_wr_ev  = cpu_wr && in_fixed(cpu_addr);
  assign bank_wr_ev = reg_wr_ev &&  cpu_addr[8];
  assign en_wr_ev   = reg_wr_ev && !cpu_addr[8];
  assign ram_wr_ev  = cpu_wr && in_ram(cpu_addr) && ram_en;
  assign dead_wr_ev = cpu_wr && in_banked(cpu_addr);

  nbc_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_wr_ev (bank_wr_ev),
    .en_wr_ev   (en_wr_ev),
    .wr_nib     (wr_nib),
    .bank       (bank),
    .ram_en     (ram_en)
  );

  nbc_rom_map #(.ROM_BYTES(ROM_BYTES)) u_map (
    .cpu_addr (cpu_addr),
    .bank     (bank),
    .rom_addr (rom_addr)
  );

  nbc_nibble_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_wr_ev),
    .idx   (cpu_addr[IDX_W-1:0]),
    .wnib  (wr_nib),
    .rnib  (stored_nib)
  );

  assign ram_rdata = ram_en ? {4'hF, stored_nib} : 8'hFF;

  // R10
  dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead_wr_ev |=> $stable(bank) && $stable(ram_en));

  // R6
  window_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_banked(cpu_addr) |-> rom_addr[13:0] == cpu_addr[13:0]);

  // R8
  disable_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_ev && (wr_nib != 4'hA) |=> ram_rdata == 8'hFF);

  // R8
  pad_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rdata[7:4] == 4'hF);

endmodule

// File: tb/tb_nibram_bank_ctrl.sv
`timescale 1ns/1ps
module tb_nibram_bank_ctrl;

  localparam int ROM_BYTES = 131072;
  localparam int ROM_AW    = $clog2(ROM_BYTES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_wr = 1'b0;
  logic [ROM_AW-1:0] rom_addr;
  logic [7:0]        ram_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nibram_bank_ctrl #(.ROM_BYTES(ROM_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_addr(rom_addr), .ram_rdata(ram_rdata)
  );

  function automatic int exp_rom(input int bank, input int a);
    if (a < 16384) return a;
    return (bank * 16384 + (a - 16384)) % ROM_BYTES;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic chk_rom(input logic [15:0] a, input int exp, input string req);
    cpu_addr = a;
    #1;
    check(int'(rom_addr) == exp, req, int'(rom_addr), exp);
  endtask

  task automatic chk_ram(input logic [15:0] a, input logic [7:0] exp, input string req);
    cpu_addr = a;
    #1;
    check(ram_rdata == exp, req, int'(ram_rdata), int'(exp));
  endtask

  task automatic t_reset;
    chk_rom(16'h4000, exp_rom(1, 16'h4000), "R1 bank after reset");
    chk_rom(16'h7FFF, exp_rom(1, 16'h7FFF), "R1 bank after reset top");
    chk_ram(16'hA000, 8'hFF, "R1 RAM disabled after reset");
  endtask

  task automatic t_fixed;
    chk_rom(16'h0000, 16'h0000, "R5 fixed window low");
    chk_rom(16'h1234, 16'h1234, "R5 fixed window mid");
    chk_rom(16'h3FFF, 16'h3FFF, "R5 fixed window top");
  endtask

  task automatic t_bank;
    wr(16'h2100, 8'hF3);
    chk_rom(16'h4567, exp_rom(3, 16'h4567), "R2 R11 bank 3, high nibble ignored");
    chk_rom(16'h3ABC, 16'h3ABC, "R5 fixed window with bank 3");
    wr(16'h0100, 8'h50);
    chk_rom(16'h4000, exp_rom(1, 16'h4000), "R3 zero nibble selects bank 1");
    wr(16'h3F00, 8'h0B);
    chk_rom(16'h7FFF, exp_rom(11, 16'h7FFF), "R6 bank 11 wraps to ROM size");
    wr(16'h0100, 8'h07);
    chk_rom(16'h5000, exp_rom(7, 16'h5000), "R6 last bank");
  endtask

  task automatic t_enable_ram;
    wr(16'h2000, 8'h05);
    chk_rom(16'h4000, exp_rom(7, 16'h4000), "R4 enable write keeps bank");
    chk_ram(16'hA000, 8'hFF, "R4 nibble 5 leaves RAM disabled");
    wr(16'h0000, 8'h3A);
    wr(16'hA000, 8'h5C);
    chk_ram(16'hA000, 8'hFC, "R4 R8 R9 enabled RAM read");
    chk_ram(16'hA200, 8'hFC, "R7 mirror at A200");
    chk_ram(16'hBE00, 8'hFC, "R7 mirror at BE00");
    wr(16'hA1FF, 8'h37);
    chk_ram(16'hB3FF, 8'hF7, "R7 R9 last entry mirrored");
    chk_ram(16'hA000, 8'hFC, "R7 other entry untouched");
  endtask

  task automatic t_disable;
    wr(16'h00FF, 8'h0B);
    chk_ram(16'hA000, 8'hFF, "R8 disabled read");
    wr(16'hA000, 8'h01);
    wr(16'h1000, 8'hFA);
    chk_ram(16'hA000, 8'hFC, "R9 disabled write ignored");
  endtask

  task automatic t_dead;
    wr(16'h4100, 8'h00);
    wr(16'h6000, 8'h0B);
    chk_rom(16'h4000, exp_rom(7, 16'h4000), "R10 bank unchanged");
    chk_ram(16'hA000, 8'hFC, "R10 enable unchanged (on)");
    wr(16'h0000, 8'h00);
    wr(16'h5000, 8'h0A);
    chk_ram(16'hA000, 8'hFF, "R10 enable unchanged (off)");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_bank();
    t_enable_ram();
    t_disable();
    t_dead();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule